// File: doc/BRIEF.md
# Software-Loaded TLB Translation Checker

This block translates an effective address through a small, fully associative TLB whose entries are loaded by software. Each request carries an effective address, an access kind (load, store or instruction fetch), the current process ID, and three mode bits: user/supervisor privilege, the instruction address space and the data address space. Every entry is compared against the request at the same time. A priority resolver then picks the outcome that an ascending scan of the entries would produce, and returns a 2-bit status, the real address and the 4-bit permission set that applied.

Each entry holds a valid bit, an effective page number, a 4-bit page-size code, an address-space bit, a process ID, a real page number and a protection byte. The protection byte has a user nibble in bits [3:0] and a supervisor nibble in bits [7:4]. Within a nibble, bit 0 grants read, bit 1 grants write and bit 2 grants execute. Entries are loaded through a one-cycle write port and can be read back combinationally through a side read port.

Top module: `tlbx_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, every entry is made invalid and `rsp_valid`, `rsp_status`, `rsp_prot` and `rsp_raddr` are cleared to zero.
- R2: An entry takes part in a translation only if it is valid, its process ID equals `req_pid`, and its page number equals the effective address at every bit above the page offset. The page offset is 10 + 2*code bits wide.
- R3: In user mode (`mode_user`=1) the permission set is protection bits [3:0]. In supervisor mode it is bits [7:4].
- R4: The entry's address-space bit must equal `mode_ispace` for a fetch (`req_kind`=2'b10) and `mode_dspace` for a load (2'b00) or store (2'b01). An entry that differs is skipped.
- R5: The lowest-indexed entry that takes part and grants the needed bit (execute bit 2 for fetch, read bit 0 for load, write bit 1 for store) decides the result. The status is 2'b00 and `rsp_prot` is that entry's permission set.
- R6: An entry that takes part but denies access does not end the scan. If no later entry grants, the status is 2'b11 for a fetch and 2'b10 for a load or store.
- R7: If no entry takes part, the status is 2'b01 and `rsp_prot` is 0. `rsp_raddr` keeps its previous value on every result whose status is not 2'b00.
- R8: On a denial, `rsp_prot` is the permission set of the highest-indexed entry that took part.
- R9: On success, `rsp_raddr` is the entry's real page number above the page offset, joined with the effective-address bits inside the offset. Size codes 0..10 select 1 KB..1 GB in steps of 4x. Codes above 10 act as 1 GB.
- R10: A request seen with `req_valid` at edge N gives a one-cycle `rsp_valid` pulse after edge N+1.
- R11: A write with `wr_en` at an edge stores all fields at `wr_idx`. The side read port then shows them combinationally for the index on `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ea | input | EA_W | Effective address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch |
| req_pid | input | PID_W | Current process ID |
| mode_user | input | 1 | 1 = user privilege |
| mode_ispace | input | 1 | Instruction address-space bit |
| mode_dspace | input | 1 | Data address-space bit |
| rsp_valid | output | 1 | Result strobe |
| rsp_status | output | 2 | 00 ok, 01 miss, 10 data denied, 11 fetch denied |
| rsp_prot | output | 4 | Permission set that applied |
| rsp_raddr | output | EA_W | Real address (updated only on success) |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid bit to write |
| wr_epn | input | EPN_W | Effective page number |
| wr_size | input | SIZE_W | Page-size code |
| wr_space | input | 1 | Address-space bit |
| wr_pid | input | PID_W | Entry process ID |
| wr_rpn | input | EPN_W | Real page number |
| wr_prot | input | 8 | Protection byte |
| rd_idx | input | IDX_W | Side read index |
| rd_valid | output | 1 | Valid bit of read entry |
| rd_epn | output | EPN_W | Page number of read entry |
| rd_size | output | SIZE_W | Size code of read entry |
| rd_space | output | 1 | Space bit of read entry |
| rd_pid | output | PID_W | Process ID of read entry |
| rd_rpn | output | EPN_W | Real page number of read entry |
| rd_prot | output | 8 | Protection byte of read entry |

## Verification
The bench loads several entries that all cover the same page and differ only in address space and permissions, then looks for the cases a wrong resolver gets wrong. A design that stops at the first denial reports a fault where a later entry grants access. A design that picks the highest granting index returns the wrong real address. A design that reports the first denied entry's permissions returns the wrong nibble. Page-size tests use a 1 KB page with an address just beyond it, and a 1 GB entry written with an out-of-range code; a bad mask either misses these or produces the wrong offset bits. Miss and fault results are checked to leave the previously returned real address unchanged.

// File: rtl/tlbx_pkg.sv
// Shared encodings for the TLB translation checker.
// Assumes permission nibbles use bit 0 = read, bit 1 = write, bit 2 = execute.
package tlbx_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'b00,
        ST_MISS      = 2'b01,
        ST_DATA_DENY = 2'b10,
        ST_EXEC_DENY = 2'b11
    } xl_status_e;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;
endpackage

// File: rtl/tlbx_entry_store.sv
// Entry storage: one-cycle write port, combinational side read port and
// flattened views of every entry for the parallel compare.
// Assumes indices at or above N are ignored on write.
module tlbx_entry_store #(
    parameter int N      = 16,
    parameter int IDX_W  = 4,
    parameter int EPN_W  = 22,
    parameter int PID_W  = 8,
    parameter int SIZE_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic                         wr_valid,
    input  logic [EPN_W-1:0]             wr_epn,
    input  logic [SIZE_W-1:0]            wr_size,
    input  logic                         wr_space,
    input  logic [PID_W-1:0]             wr_pid,
    input  logic [EPN_W-1:0]             wr_rpn,
    input  logic [7:0]                   wr_prot,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic                         rd_valid,
    output logic [EPN_W-1:0]             rd_epn,
    output logic [SIZE_W-1:0]            rd_size,
    output logic                         rd_space,
    output logic [PID_W-1:0]             rd_pid,
    output logic [EPN_W-1:0]             rd_rpn,
    output logic [7:0]                   rd_prot,
    output logic [N-1:0]                 ent_valid,
    output logic [N-1:0][EPN_W-1:0]      ent_epn,
    output logic [N-1:0][SIZE_W-1:0]     ent_size,
    output logic [N-1:0]                 ent_space,
    output logic [N-1:0][PID_W-1:0]      ent_pid,
    output logic [N-1:0][EPN_W-1:0]      ent_rpn,
    output logic [N-1:0][7:0]            ent_prot
);
    // Clear all entries on reset, otherwise store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_epn   <= '0;
            ent_size  <= '0;
            ent_space <= '0;
            ent_pid   <= '0;
            ent_rpn   <= '0;
            ent_prot  <= '0;
        end else if (wr_en && (int'(wr_idx) < N)) begin
            ent_valid[wr_idx] <= wr_valid;
            ent_epn[wr_idx]   <= wr_epn;
            ent_size[wr_idx]  <= wr_size;
            ent_space[wr_idx] <= wr_space;
            ent_pid[wr_idx]   <= wr_pid;
            ent_rpn[wr_idx]   <= wr_rpn;
            ent_prot[wr_idx]  <= wr_prot;
        end
    end

    // Side read of the selected entry; out-of-range indices read as zero.
    always_comb begin
        rd_valid = 1'b0;
        rd_epn   = '0;
        rd_size  = '0;
        rd_space = 1'b0;
        rd_pid   = '0;
        rd_rpn   = '0;
        rd_prot  = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(rd_idx) == i) begin
                rd_valid = ent_valid[i];
                rd_epn   = ent_epn[i];
                rd_size  = ent_size[i];
                rd_space = ent_space[i];
                rd_pid   = ent_pid[i];
                rd_rpn   = ent_rpn[i];
                rd_prot  = ent_prot[i];
            end
        end
    end
endmodule

// File: rtl/tlbx_entry_match.sv
// Compares one entry against a request: tag under the page-size mask, process
// ID and address-space bit. Selects the privilege nibble and tests the needed
// permission bit. Assumes 2*MAX_CODE <= EPN_W; larger codes clamp to MAX_CODE.
module tlbx_entry_match #(
    parameter int EPN_W    = 22,
    parameter int PID_W    = 8,
    parameter int SIZE_W   = 4,
    parameter int MAX_CODE = 10
) (
    input  logic              ent_valid,
    input  logic [EPN_W-1:0]  ent_epn,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic              ent_space,
    input  logic [PID_W-1:0]  ent_pid,
    input  logic [EPN_W-1:0]  ent_rpn,
    input  logic [7:0]        ent_prot,
    input  logic [EPN_W-1:0]  req_epn,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              want_space,
    input  logic              is_user,
    input  logic [1:0]        need_bit,
    output logic              considered,
    output logic              grants,
    output logic [3:0]        nibble,
    output logic [EPN_W-1:0]  page
);
    logic [SIZE_W-1:0] code_c;
    logic [EPN_W-1:0]  low_mask;
    logic              tag_hit;

    // Build the mask of page-number bits that lie inside the page offset.
    always_comb begin
        code_c = (int'(ent_size) > MAX_CODE) ? SIZE_W'(MAX_CODE) : ent_size;
        for (int i = 0; i < EPN_W; i++) begin
            low_mask[i] = (i < 2 * int'(code_c));
        end
    end

    // Decide whether the entry takes part and whether it grants the access.
    always_comb begin
        tag_hit    = ((req_epn ^ ent_epn) & ~low_mask) == '0;
        considered = ent_valid && tag_hit && (ent_pid == req_pid)
                     && (ent_space == want_space);
        nibble     = is_user ? ent_prot[3:0] : ent_prot[7:4];
        grants     = considered && nibble[need_bit];
        page       = (ent_rpn & ~low_mask) | (req_epn & low_mask);
    end
endmodule

// File: rtl/tlbx_resolve.sv
// Reduces per-entry compare results to the outcome of an ascending scan:
// lowest granting entry wins, otherwise the last matching entry names the
// fault. Assumes inputs are stable combinational results of one request.
module tlbx_resolve #(
    parameter int N     = 16,
    parameter int EPN_W = 22
) (
    input  logic [N-1:0]            considered,
    input  logic [N-1:0]            grants,
    input  logic [N-1:0][3:0]       nibble,
    input  logic [N-1:0][EPN_W-1:0] page,
    input  logic                    is_fetch,
    output tlbx_pkg::xl_status_e    status,
    output logic [3:0]              prot,
    output logic [EPN_W-1:0]        win_page,
    output logic                    win_ok
);
    logic       any_hit;
    logic [3:0] last_nib;
    logic [3:0] win_nib;

    // Priority pick of the first grant and the last considered entry.
    always_comb begin
        win_ok   = 1'b0;
        win_nib  = '0;
        win_page = '0;
        any_hit  = 1'b0;
        last_nib = '0;
        for (int i = 0; i < N; i++) begin
            if (grants[i] && !win_ok) begin
                win_ok   = 1'b1;
                win_nib  = nibble[i];
                win_page = page[i];
            end
            if (considered[i]) begin
                any_hit  = 1'b1;
                last_nib = nibble[i];
            end
        end
    end

    // Map the scan outcome to the status code and reported permission set.
    always_comb begin
        if (win_ok) begin
            status = tlbx_pkg::ST_OK;
            prot   = win_nib;
        end else if (any_hit) begin
            status = is_fetch ? tlbx_pkg::ST_EXEC_DENY : tlbx_pkg::ST_DATA_DENY;
            prot   = last_nib;
        end else begin
            status = tlbx_pkg::ST_MISS;
            prot   = '0;
        end
    end
endmodule

// File: rtl/tlbx_xlate.sv
// Top of the TLB translation checker. Registers the request, compares it
// against every entry in parallel, and registers the resolved result one
// cycle later. Assumes entries are not rewritten while a request is in flight.
module tlbx_xlate #(
    parameter int NUM_ENTRIES   = 16,
    parameter int EA_W          = 32,
    parameter int PAGE_LG_MIN   = 10,
    parameter int PID_W         = 8,
    parameter int SIZE_W        = 4,
    parameter int MAX_SIZE_CODE = 10,
    localparam int EPN_W        = EA_W - PAGE_LG_MIN,
    localparam int IDX_W        = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [1:0]        req_kind,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              mode_user,
    input  logic              mode_ispace,
    input  logic              mode_dspace,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [3:0]        rsp_prot,
    output logic [EA_W-1:0]   rsp_raddr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [EPN_W-1:0]  wr_epn,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_space,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [EPN_W-1:0]  wr_rpn,
    input  logic [7:0]        wr_prot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [EPN_W-1:0]  rd_epn,
    output logic [SIZE_W-1:0] rd_size,
    output logic              rd_space,
    output logic [PID_W-1:0]  rd_pid,
    output logic [EPN_W-1:0]  rd_rpn,
    output logic [7:0]        rd_prot
);
    import tlbx_pkg::*;

    logic [NUM_ENTRIES-1:0]             e_valid;
    logic [NUM_ENTRIES-1:0][EPN_W-1:0]  e_epn;
    logic [NUM_ENTRIES-1:0][SIZE_W-1:0] e_size;
    logic [NUM_ENTRIES-1:0]             e_space;
    logic [NUM_ENTRIES-1:0][PID_W-1:0]  e_pid;
    logic [NUM_ENTRIES-1:0][EPN_W-1:0]  e_rpn;
    logic [NUM_ENTRIES-1:0][7:0]        e_prot;

    logic              q_valid;
    logic [EA_W-1:0]   q_ea;
    acc_kind_e         q_kind;
    logic [PID_W-1:0]  q_pid;
    logic              q_user;
    logic              q_ispace;
    logic              q_dspace;

    logic              is_fetch;
    logic              want_space;
    logic [1:0]        need_bit;

    logic [NUM_ENTRIES-1:0]            hit_v;
    logic [NUM_ENTRIES-1:0]            grant_v;
    logic [NUM_ENTRIES-1:0][3:0]       nib_v;
    logic [NUM_ENTRIES-1:0][EPN_W-1:0] page_v;

    xl_status_e        res_status;
    logic [3:0]        res_prot;
    logic [EPN_W-1:0]  res_page;
    logic              res_ok;

    tlbx_entry_store #(
        .N(NUM_ENTRIES), .IDX_W(IDX_W), .EPN_W(EPN_W),
        .PID_W(PID_W), .SIZE_W(SIZE_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_epn(wr_epn),
        .wr_size(wr_size), .wr_space(wr_space), .wr_pid(wr_pid),
        .wr_rpn(wr_rpn), .wr_prot(wr_prot),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_epn(rd_epn),
        .rd_size(rd_size), .rd_space(rd_space), .rd_pid(rd_pid),
        .rd_rpn(rd_rpn), .rd_prot(rd_prot),
        .ent_valid(e_valid), .ent_epn(e_epn), .ent_size(e_size),
        .ent_space(e_space), .ent_pid(e_pid), .ent_rpn(e_rpn),
        .ent_prot(e_prot)
    );

    // Capture the request and its mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_ea     <= '0;
            q_kind   <= ACC_LOAD;
            q_pid    <= '0;
            q_user   <= 1'b0;
            q_ispace <= 1'b0;
            q_dspace <= 1'b0;
        end else begin
            q_valid <= req_valid;
            if (req_valid) begin
                q_ea     <= req_ea;
                q_kind   <= acc_kind_e'(req_kind);
                q_pid    <= req_pid;
                q_user   <= mode_user;
                q_ispace <= mode_ispace;
                q_dspace <= mode_dspace;
            end
        end
    end

    // Derive the needed permission bit and the address space to compare.
    always_comb begin
        is_fetch   = (q_kind == ACC_FETCH);
        want_space = is_fetch ? q_ispace : q_dspace;
        case (q_kind)
            ACC_FETCH: need_bit = 2'(PERM_EX);
            ACC_STORE: need_bit = 2'(PERM_WR);
            default:   need_bit = 2'(PERM_RD);
        endcase
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
        tlbx_entry_match #(
            .EPN_W(EPN_W), .PID_W(PID_W), .SIZE_W(SIZE_W),
            .MAX_CODE(MAX_SIZE_CODE)
        ) match_i (
            .ent_valid(e_valid[g]), .ent_epn(e_epn[g]), .ent_size(e_size[g]),
            .ent_space(e_space[g]), .ent_pid(e_pid[g]), .ent_rpn(e_rpn[g]),
            .ent_prot(e_prot[g]),
            .req_epn(q_ea[EA_W-1:PAGE_LG_MIN]), .req_pid(q_pid),
            .want_space(want_space), .is_user(q_user), .need_bit(need_bit),
            .considered(hit_v[g]), .grants(grant_v[g]),
            .nibble(nib_v[g]), .page(page_v[g])
        );
    end

    tlbx_resolve #(.N(NUM_ENTRIES), .EPN_W(EPN_W)) resolve_i (
        .considered(hit_v), .grants(grant_v), .nibble(nib_v), .page(page_v),
        .is_fetch(is_fetch), .status(res_status), .prot(res_prot),
        .win_page(res_page), .win_ok(res_ok)
    );

    // Register the result; the real address moves only on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= 2'b00;
            rsp_prot   <= '0;
            rsp_raddr  <= '0;
        end else begin
            rsp_valid <= q_valid;
            if (q_valid) begin
                rsp_status <= res_status;
                rsp_prot   <= res_prot;
                if (res_ok) begin
                    rsp_raddr <= {res_page, q_ea[PAGE_LG_MIN-1:0]};
                end
            end
        end
    end
endmodule

// File: rtl/tlbx_xlate_chk.sv
// Temporal checks on the translation checker ports, bound to the top module.
module tlbx_xlate_chk #(
    parameter int EA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic            rsp_valid,
    input logic [1:0]      rsp_status,
    input logic [3:0]      rsp_prot,
    input logic [EA_W-1:0] rsp_raddr
);
    // R10
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rsp_valid && rsp_raddr == '0 && rsp_prot == '0));

    // R7
    miss_prot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b01) |-> rsp_prot == 4'h0);

    // R7
    raddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'b00) |-> $stable(rsp_raddr));

    // R5
    ok_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b00) |->
        (($past(req_kind, 2) == 2'b10) ? rsp_prot[2] :
         ($past(req_kind, 2) == 2'b01) ? rsp_prot[1] : rsp_prot[0]));

    // R6
    exec_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b11) |->
        (!rsp_prot[2] && $past(req_kind, 2) == 2'b10));

    // R6
    data_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b10) |-> $past(req_kind, 2) != 2'b10);
endmodule

bind tlbx_xlate tlbx_xlate_chk #(.EA_W(EA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_prot(rsp_prot),
    .rsp_raddr(rsp_raddr)
);

// File: tb/tlbx_xlate_tb_top.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module tlbx_xlate_tb_top;
    localparam int EA_W = 32;
    localparam int IDX_W = 4;
    localparam int EPN_W = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [EA_W-1:0] req_ea = '0;
    logic [1:0] req_kind = '0;
    logic [7:0] req_pid = '0;
    logic mode_user = 1'b0, mode_ispace = 1'b0, mode_dspace = 1'b0;
    logic rsp_valid;
    logic [1:0] rsp_status;
    logic [3:0] rsp_prot;
    logic [EA_W-1:0] rsp_raddr;
    logic wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic wr_valid = 1'b0;
    logic [EPN_W-1:0] wr_epn = '0;
    logic [3:0] wr_size = '0;
    logic wr_space = 1'b0;
    logic [7:0] wr_pid = '0;
    logic [EPN_W-1:0] wr_rpn = '0;
    logic [7:0] wr_prot = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic rd_valid;
    logic [EPN_W-1:0] rd_epn;
    logic [3:0] rd_size;
    logic rd_space;
    logic [7:0] rd_pid;
    logic [EPN_W-1:0] rd_rpn;
    logic [7:0] rd_prot;

    typedef struct {
        string      tag;
        int         cyc;
        logic [1:0] st;
        logic [3:0] pr;
        logic [31:0] ra;
    } exp_t;

    exp_t exp_q[$];
    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    tlbx_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_kind(req_kind), .req_pid(req_pid), .mode_user(mode_user),
        .mode_ispace(mode_ispace), .mode_dspace(mode_dspace),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_prot(rsp_prot),
        .rsp_raddr(rsp_raddr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_epn(wr_epn), .wr_size(wr_size),
        .wr_space(wr_space), .wr_pid(wr_pid), .wr_rpn(wr_rpn),
        .wr_prot(wr_prot), .rd_idx(rd_idx), .rd_valid(rd_valid),
        .rd_epn(rd_epn), .rd_size(rd_size), .rd_space(rd_space),
        .rd_pid(rd_pid), .rd_rpn(rd_rpn), .rd_prot(rd_prot)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected rsp_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cyc == e.cyc, $sformatf("%s timing actual=%0d expected=%0d", e.tag, cyc, e.cyc));
                chk(rsp_status == e.st, $sformatf("%s status actual=%b expected=%b", e.tag, rsp_status, e.st));
                chk(rsp_prot == e.pr, $sformatf("%s prot actual=%h expected=%h", e.tag, rsp_prot, e.pr));
                chk(rsp_raddr == e.ra, $sformatf("%s raddr actual=%h expected=%h", e.tag, rsp_raddr, e.ra));
            end
        end
    end

    task automatic put_entry(int idx, bit v, logic [31:0] ea, int sz, bit sp,
                             int pid, logic [31:0] ra, logic [7:0] pr);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v; wr_epn = ea[31:10];
        wr_size = 4'(sz); wr_space = sp; wr_pid = 8'(pid); wr_rpn = ra[31:10];
        wr_prot = pr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue one request and queue its expected result.
    task automatic xlate(string tag, logic [31:0] ea, logic [1:0] kind, int pid,
                         bit usr, bit isp, bit dsp, logic [1:0] st,
                         logic [3:0] pr, logic [31:0] ra);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_kind = kind; req_pid = 8'(pid);
        mode_user = usr; mode_ispace = isp; mode_dspace = dsp;
        e.tag = tag; e.cyc = cyc + 2; e.st = st; e.pr = pr; e.ra = ra;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!rsp_valid && rsp_status == 2'b00 && rsp_prot == 4'h0 && rsp_raddr == 32'h0,
            $sformatf("R1 outputs actual=%b/%b/%h/%h expected=0/00/0/0",
                      rsp_valid, rsp_status, rsp_prot, rsp_raddr));
        chk(!rd_valid, $sformatf("R1 entry valid actual=%b expected=0", rd_valid));

        put_entry(0, 1, 32'h1000_0000, 1, 0, 5, 32'h8000_0000, 8'h31);
        xlate("R2_R3_R9 user load", 32'h1000_0ABC, 2'b00, 5, 1, 0, 0, 2'b00, 4'h1, 32'h8000_0ABC);
        xlate("R3_R6 user store denied", 32'h1000_0ABC, 2'b01, 5, 1, 0, 0, 2'b10, 4'h1, 32'h8000_0ABC);
        xlate("R3 super store", 32'h1000_0F00, 2'b01, 5, 0, 0, 0, 2'b00, 4'h3, 32'h8000_0F00);
        xlate("R2_R7 pid mismatch", 32'h1000_0F00, 2'b00, 6, 0, 0, 0, 2'b01, 4'h0, 32'h8000_0F00);
        xlate("R2 tag outside page", 32'h1000_1000, 2'b00, 5, 0, 0, 0, 2'b01, 4'h0, 32'h8000_0F00);
        xlate("R4 data space mismatch", 32'h1000_0F00, 2'b00, 5, 0, 0, 1, 2'b01, 4'h0, 32'h8000_0F00);
        xlate("R6 fetch denied", 32'h1000_0F00, 2'b10, 5, 0, 0, 0, 2'b11, 4'h3, 32'h8000_0F00);

        put_entry(1, 1, 32'h1000_0000, 1, 1, 5, 32'h9000_0000, 8'h77);
        put_entry(2, 1, 32'h1000_0000, 1, 0, 5, 32'hA000_0000, 8'h44);
        put_entry(3, 1, 32'h1000_0000, 1, 0, 5, 32'hB000_0000, 8'h22);
        rd_idx = 4'd1;
        @(negedge clk);
        // R11: side read of entry 1
        chk(rd_valid && rd_epn == 22'h04_0000 && rd_size == 4'd1 && rd_space &&
            rd_pid == 8'd5 && rd_rpn == 22'h24_0000 && rd_prot == 8'h77,
            $sformatf("R11 readback actual=%b/%h/%h/%b/%h/%h/%h expected=1/040000/1/1/05/240000/77",
                      rd_valid, rd_epn, rd_size, rd_space, rd_pid, rd_rpn, rd_prot));

        xlate("R4 fetch uses ispace", 32'h1000_0010, 2'b10, 5, 1, 1, 0, 2'b00, 4'h7, 32'h9000_0010);
        xlate("R6 scan continues fetch", 32'h1000_0020, 2'b10, 5, 0, 0, 0, 2'b00, 4'h4, 32'hA000_0020);
        xlate("R6 scan continues store", 32'h1000_0030, 2'b01, 5, 1, 0, 0, 2'b00, 4'h2, 32'hB000_0030);
        xlate("R5 lowest index wins", 32'h1000_0040, 2'b01, 5, 0, 0, 0, 2'b00, 4'h3, 32'h8000_0040);

        put_entry(2, 0, 32'h1000_0000, 1, 0, 5, 32'hA000_0000, 8'h44);
        rd_idx = 4'd2;
        @(negedge clk);
        chk(!rd_valid, $sformatf("R11 invalidated actual=%b expected=0", rd_valid));
        xlate("R8 last match prot", 32'h1000_0050, 2'b10, 5, 1, 0, 0, 2'b11, 4'h2, 32'h8000_0040);

        put_entry(5, 1, 32'h4000_0000, 15, 0, 9, 32'hC000_0000, 8'h11);
        put_entry(6, 1, 32'h2000_0400, 0, 0, 9, 32'h0000_1C00, 8'h11);
        rd_idx = 4'd5;
        @(negedge clk);
        chk(rd_size == 4'd15, $sformatf("R11 size code actual=%0d expected=15", rd_size));
        xlate("R9 clamped 1GB page", 32'h7ABC_DEF0, 2'b00, 9, 1, 0, 0, 2'b00, 4'h1, 32'hFABC_DEF0);
        xlate("R9 1KB page", 32'h2000_07FF, 2'b00, 9, 1, 0, 0, 2'b00, 4'h1, 32'h0000_1FFF);
        xlate("R9_R7 beyond 1KB page", 32'h2000_0800, 2'b00, 9, 1, 0, 0, 2'b01, 4'h0, 32'h0000_1FFF);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, $sformatf("R10 pending results actual=%0d expected=0", exp_q.size()));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule